// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block holds the 16-bit I/O window setting of a bridge that joins two buses, and decodes 16-bit I/O addresses against that window. Software sets the window through a small synchronous write port with two byte enables and reads it back through a combinational read port. The window is an inclusive address range built from a lower bound and an upper bound. The window has a 4 KB granularity by default. A configuration input, the fine-grain enable, switches it to 1 KB granularity. While that enable is set, two additional bits of each bound become writable and take part in the compare.

The block decodes two independent address streams. A request arriving on the upstream side is passed downstream only when its address falls inside the window and the I/O space enable input is high. A request arriving on the downstream side is passed on when its address falls inside the window. A request that is not passed on is refused with a master-abort flag. All decode outputs are combinational from the address and the stored window, so they are valid in the same cycle as the request.

The reset input is asynchronous and active low. Inside the block it is synchronized, so it takes effect at once but releases on the clock.

Top module: `io_window_decoder`

## Requirements
- R1: After reset the register reads 0000h.
- R2: Register bits 15:12 (upper bound, address bits 15:12) and bits 7:4 (lower bound, address bits 15:12) are always writable. A write with cfg_be[1] high updates bits 15:8. A write with cfg_be[0] high updates bits 7:0. A byte whose enable is low keeps its value.
- R3: Bits 9:8 and bits 1:0 always read 0, whatever value is written to them.
- R4: While en_1k is high, bits 11:10 (upper bound, address bits 11:10) and bits 3:2 (lower bound, address bits 11:10) are writable and read back. While en_1k is low, writes to these bits are ignored and they read 0. Their stored value is kept and reads back again once en_1k is set.
- R5: With en_1k low, the window runs from {bits 7:4, 000h} to {bits 15:12, FFFh}, and both ends are included.
- R6: With en_1k high, the window runs from {bits 7:4, bits 3:2, ten zero bits} to {bits 15:12, bits 11:10, 3FFh}, and both ends are included.
- R7: A valid upstream request raises up_fwd when its address is inside the window and io_space_en is high. Otherwise it raises up_abort.
- R8: A valid downstream request raises dn_fwd when its address is inside the window. An address outside the window raises dn_abort.
- R9: When the lower bound exceeds the upper bound, the window is empty. No upstream request is forwarded and every downstream request is aborted.
- R10: The forward and abort outputs respond in the same cycle as the request. Both outputs of a side are 0 while that side's valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_1k | input | 1 | Fine-grain (1 KB) window enable |
| io_space_en | input | 1 | I/O space enable that gates upstream forwarding |
| cfg_wr | input | 1 | Register write strobe |
| cfg_be | input | 2 | Byte enables for the write (bit 1 selects bits 15:8, bit 0 selects bits 7:0) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| up_valid | input | 1 | Upstream request valid |
| up_addr | input | 16 | Upstream I/O address |
| up_fwd | output | 1 | Upstream request is forwarded downstream |
| up_abort | output | 1 | Upstream request ends in master abort |
| dn_valid | input | 1 | Downstream request valid |
| dn_addr | input | 16 | Downstream I/O address |
| dn_fwd | output | 1 | Downstream request is forwarded |
| dn_abort | output | 1 | Downstream request ends in master abort |

## Verification
Several properties are checked on every cycle:
- a held byte enable, or a locked fine field, leaves the register unchanged;
- a write loads the upper-bound field;
- no upstream request is forwarded while io_space_en is low;
- an out-of-window downstream request is aborted;
- an empty window forwards nothing;
- an idle side raises no output.

The exact window edges cannot be proven by those properties. Neither can the 4 KB and 1 KB bound formulas, the retention of the fine bits across mode changes, or the reset value. The bench shows these with sweeps. It covers every upper-field pair in 4 KB mode and a broad set of field combinations in 1 KB mode. It probes both edges of every 1 KB block of the address space.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int ADDR_W   = 16;
  localparam int FINE_LSB = 10;
  localparam int FN_W     = 2;
  localparam int HI_W     = ADDR_W - FINE_LSB - FN_W;
  localparam int REG_W    = 16;
  localparam int LIM_HI_LSB = 12;
  localparam int LIM_FN_LSB = 10;
  localparam int BAS_HI_LSB = 4;
  localparam int BAS_FN_LSB = 2;
  localparam int N_SIDE     = 2;

  typedef struct packed {
    logic [HI_W-1:0] lim_hi;
    logic [FN_W-1:0] lim_fn;
    logic [HI_W-1:0] bas_hi;
    logic [FN_W-1:0] bas_fn;
  } win_cfg_t;
endpackage

// File: rtl/io_win_reg.sv
module io_win_reg
  import io_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_fine,
  input  logic             wr,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  output win_cfg_t         cfg_q,
  output logic [REG_W-1:0] rdata
);
  win_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr && be[1]) begin
      cfg_d.lim_hi = wdata[LIM_HI_LSB +: HI_W];
      if (en_fine) cfg_d.lim_fn = wdata[LIM_FN_LSB +: FN_W];
    end
    if (wr && be[0]) begin
      cfg_d.bas_hi = wdata[BAS_HI_LSB +: HI_W];
      if (en_fine) cfg_d.bas_fn = wdata[BAS_FN_LSB +: FN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata = '0;
    rdata[LIM_HI_LSB +: HI_W] = cfg_q.lim_hi;
    rdata[BAS_HI_LSB +: HI_W] = cfg_q.bas_hi;
    if (en_fine) begin
      rdata[LIM_FN_LSB +: FN_W] = cfg_q.lim_fn;
      rdata[BAS_FN_LSB +: FN_W] = cfg_q.bas_fn;
    end
  end

  p_be_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !be[0]) |=> $stable(cfg_q.bas_hi) && $stable(cfg_q.bas_fn));
  p_lim_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be[1]) |=> (cfg_q.lim_hi == $past(wdata[LIM_HI_LSB +: HI_W])));
  p_fine_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !en_fine) |=> $stable(cfg_q.lim_fn) && $stable(cfg_q.bas_fn));
endmodule

// File: rtl/io_win_bounds.sv
module io_win_bounds
  import io_win_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic              en_fine,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  logic [FN_W-1:0] lo_fn, hi_fn;

  always_comb begin
    lo_fn = en_fine ? cfg.bas_fn : '0;
    hi_fn = en_fine ? cfg.lim_fn : '1;
    lo    = {cfg.bas_hi, lo_fn, {FINE_LSB{1'b0}}};
    hi    = {cfg.lim_hi, hi_fn, {FINE_LSB{1'b1}}};
  end
endmodule

// File: rtl/io_win_hit.sv
module io_win_hit
  import io_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              hit
);
  always_comb hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import io_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_1k,
  input  logic        io_space_en,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        up_valid,
  input  logic [15:0] up_addr,
  output logic        up_fwd,
  output logic        up_abort,
  input  logic        dn_valid,
  input  logic [15:0] dn_addr,
  output logic        dn_fwd,
  output logic        dn_abort
);
  logic              rst_s1, rst_sn;
  win_cfg_t          cfg_q;
  logic [ADDR_W-1:0] win_lo, win_hi;
  logic [ADDR_W-1:0] side_addr [N_SIDE];
  logic [N_SIDE-1:0] side_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  io_win_reg u_reg (
    .clk(clk), .rst_n(rst_sn), .en_fine(en_1k), .wr(cfg_wr), .be(cfg_be),
    .wdata(cfg_wdata), .cfg_q(cfg_q), .rdata(cfg_rdata)
  );

  io_win_bounds u_bounds (
    .cfg(cfg_q), .en_fine(en_1k), .lo(win_lo), .hi(win_hi)
  );

  always_comb begin
    side_addr[0] = up_addr;
    side_addr[1] = dn_addr;
  end

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    io_win_hit u_hit (
      .addr(side_addr[s]), .lo(win_lo), .hi(win_hi), .hit(side_hit[s])
    );
  end

  always_comb begin
    up_fwd   = up_valid && side_hit[0] && io_space_en;
    up_abort = up_valid && !(side_hit[0] && io_space_en);
    dn_fwd   = dn_valid && side_hit[1];
    dn_abort = dn_valid && !side_hit[1];
  end

  p_up_gate_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    up_fwd |-> io_space_en && (up_addr >= win_lo) && (up_addr <= win_hi));
  p_dn_out_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_valid && ((dn_addr < win_lo) || (dn_addr > win_hi))) |-> (dn_abort && !dn_fwd));
  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (win_lo > win_hi) |-> (!up_fwd && !dn_fwd));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!up_valid |-> !up_fwd && !up_abort) and (!dn_valid |-> !dn_fwd && !dn_abort));
endmodule

// File: tb/io_window_decoder_tb.sv
`timescale 1ns/100ps
module io_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_1k, io_space_en, cfg_wr;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        up_valid, dn_valid;
  logic [15:0] up_addr, dn_addr;
  logic        up_fwd, up_abort, dn_fwd, dn_abort;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  io_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .en_1k(en_1k), .io_space_en(io_space_en),
    .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .up_valid(up_valid), .up_addr(up_addr), .up_fwd(up_fwd), .up_abort(up_abort),
    .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_fwd(dn_fwd), .dn_abort(dn_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [15:0] exp_rd(int lh, int lf, int bh, int bf, bit fine);
    return 16'((lh << 12) | ((fine ? lf : 0) << 10) | (bh << 4) | ((fine ? bf : 0) << 2));
  endfunction

  // Sweep both edges of every 1 KB block against the window of this config.
  task automatic sweep(input string req, input int lh, input int lf, input int bh,
                       input int bf, input bit fine, input bit ioen);
    int lo, hi, a;
    bit in;
    lo = bh * 4096 + (fine ? bf * 1024 : 0);
    hi = lh * 4096 + (fine ? lf * 1024 + 1023 : 4095);
    io_space_en = ioen;
    up_valid = 1'b1; dn_valid = 1'b1;
    for (int blk = 0; blk < 64; blk++) begin
      for (int e = 0; e < 2; e++) begin
        a = blk * 1024 + e * 1023;
        up_addr = 16'(a); dn_addr = 16'(a);
        #0.1;
        in = (a >= lo) && (a <= hi);
        // R7 upstream decision, R8 downstream decision, R9 when lo > hi
        chk({req, "/R7"}, {up_fwd, up_abort}, {in && ioen, !(in && ioen)});
        chk({req, "/R8"}, {dn_fwd, dn_abort}, {in, !in});
      end
    end
    up_valid = 1'b0; dn_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_1k = 1'b0; io_space_en = 1'b0; cfg_wr = 1'b0;
    cfg_be = 2'b00; cfg_wdata = '0; up_valid = 1'b0; dn_valid = 1'b0;
    up_addr = '0; dn_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", cfg_rdata, 16'h0000);
    // R10 idle: no outputs while valids are low
    #0.1;
    chk("R10 idle outputs", {up_fwd, up_abort, dn_fwd, dn_abort}, 4'b0000);
    // R10 same-cycle response: reset window 0000h..0FFFh, address 0 hits at once
    up_valid = 1'b1; up_addr = 16'h0000; io_space_en = 1'b1; #0.1;
    chk("R10 same cycle", {up_fwd, up_abort}, 2'b10);
    up_valid = 1'b0;

    // R2/R3/R5: all upper-field pairs in 4 KB mode; capability and fine bits written as 1
    for (int lh = 0; lh < 16; lh++) begin
      for (int bh = 0; bh < 16; bh++) begin
        wr_reg(2'b11, 16'((lh << 12) | 16'h0F00 | (bh << 4) | 16'h000F));
        chk("R2/R3/R4 readback 4K", cfg_rdata, exp_rd(lh, 0, bh, 0, 1'b0));
        sweep("R5/R9 4K", lh, 0, bh, 0, 1'b0, 1'((lh ^ bh) & 1) | (lh == bh));
      end
    end

    // R2 byte enables: each enable gates only its own byte
    wr_reg(2'b11, 16'h5030);
    wr_reg(2'b10, 16'hA0F0);
    chk("R2 be[1] only", cfg_rdata, 16'hA030);
    wr_reg(2'b01, 16'h7090);
    chk("R2 be[0] only", cfg_rdata, 16'hA090);
    wr_reg(2'b00, 16'hFFFF);
    chk("R2 no enables", cfg_rdata, 16'hA090);

    // R4/R6: 1 KB mode sweep
    en_1k = 1'b1;
    for (int lh = 0; lh < 16; lh += 3) begin
      for (int bh = 0; bh < 16; bh += 3) begin
        for (int lf = 0; lf < 4; lf++) begin
          for (int bf = 0; bf < 4; bf++) begin
            wr_reg(2'b11, 16'((lh << 12) | (lf << 10) | 16'h0300 | (bh << 4) | (bf << 2) | 16'h0003));
            chk("R3/R4 readback 1K", cfg_rdata, exp_rd(lh, lf, bh, bf, 1'b1));
            sweep("R6/R9 1K", lh, lf, bh, bf, 1'b1, 1'(lf != 1));
          end
        end
      end
    end

    // R4 retention and write lock while fine mode is off
    wr_reg(2'b11, 16'h2C1C);
    chk("R4 fine written", cfg_rdata, 16'h2C1C);
    en_1k = 1'b0; #0.1;
    chk("R4 fine reads zero", cfg_rdata, 16'h2010);
    wr_reg(2'b11, 16'h2010);
    sweep("R5 after mode switch", 2, 0, 1, 0, 1'b0, 1'b1);
    en_1k = 1'b1; #0.1;
    chk("R4 fine retained", cfg_rdata, 16'h2C1C);
    sweep("R6 after mode switch", 2, 3, 1, 3, 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule